// File: doc/BRIEF.md
# Bit-Serial Nine-Word Median Sorter

This block finds the median of nine unsigned words that arrive bit-serially, most significant bit first, one bit of every word per clock. The nine bit lanes pass through a nine-stage odd/even transposition network. Each stage is a column of bitwise compare-and-swap cells, followed by a register column. A cell starts every word undecided. It copies its inputs through unchanged until the first bit position where they differ. At that point it commits, for the rest of the word, either to keep the order or to exchange the lanes. The larger word always ends up on the upper lane, so the words leave the network in descending order with the median in the middle lane.

The word length is not fixed in hardware. A start strobe that accompanies the first bit of each word moves down the pipeline next to the data and clears each cell's decision as it arrives. Words can therefore follow one another with no idle cycles, and each word can have a different length. A valid qualifier lets the source pause inside a word. Each stage also has an upper and a lower extension rail. For a nine-word window the upper rails are held at one and the lower rails at zero, so the boundary cells never move a real word. Several instances can use these rails to share a wider window.

Top module: `bit_serial_median`

## Requirements
- R1: The bit sequence on `med_o`, read MSB first over one output word, equals the median of the nine unsigned input words. Input word p is the sequence on `bits_i[p]`. This holds for any word length from 1 bit upward.
- R2: Over one output word, `sorted_o[p]` carries the nine input words in descending order. Lane 0 is the largest word and lane 8 the smallest.
- R3: The first bit of a median word is presented with `vld_o` high 9 clocks after the rising edge that accepts the word's first input bit.
- R4: `sow_i` must be high only together with `vld_i`, and it marks the first bit of a word. Each cell decides its order from the first bit position where its two inputs differ. Words sent back to back with no idle cycle give independent results.
- R5: Cycles with `vld_i` low neither change any cell's decision nor contribute a bit. The output shows the same valid pattern as the input, delayed 9 clocks. At most 9 valid bits are ever in flight.
- R6: `first_o` is high on the first output bit of each word. `last_o` is high on the output bit whose next valid bit in the pipeline starts a new word, or that has no valid bit behind it. Idle gaps inside a word must be at most 7 cycles long.
- R7: Upper rail j feeds the cell above lane 0 in stage 2j+1, and lower rail j feeds the cell below lane 8 in stage 2j (stages counted from 0). When all upper rails are held at 1 and all lower rails at 0, `ext_up_o` reads all ones and `ext_dn_o` reads all zeros, and the rails do not alter the result.
- R8: While `rst_ni` is low, every output is 0 and every cell is undecided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input bits valid this cycle |
| sow_i | input | 1 | First (most significant) bit of a new word |
| bits_i | input | 9 | One bit from each of the nine words; bit p is word p |
| ext_up_i | input | 4 | Upper extension rails, one per odd stage |
| ext_dn_i | input | 5 | Lower extension rails, one per even stage |
| med_o | output | 1 | Current bit of the median |
| sorted_o | output | 9 | Current bit of every sorted lane, lane 0 largest |
| vld_o | output | 1 | Output bits valid |
| first_o | output | 1 | First bit of an output word |
| last_o | output | 1 | Last bit of an output word |
| ext_up_o | output | 4 | Upper rails after their boundary cells |
| ext_dn_o | output | 5 | Lower rails after their boundary cells |

## Verification
The assertions assume three things about the inputs. A start strobe never appears without a valid bit. Gaps inside a word are shorter than the pipeline, so at most nine words can be in flight. The extension rails stay tied high above and low below for the whole run, so a boundary cell can never lock into the swap state. The stimulus ties the rails once and never changes them, raises `sow_i` only on a valid first bit, and inserts only single-cycle gaps inside words. Within those limits it sweeps every 9-bit pattern at word length 1 and random words at several longer lengths, with and without gaps and idle stretches between words.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic [1:0] {
    CS_EQ   = 2'd0,
    CS_PASS = 2'd1,
    CS_SWAP = 2'd2
  } cs_state_e;
endpackage

// File: rtl/bsm_cswap_cell.sv
module bsm_cswap_cell
  import bsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic sow_i,
  input  logic a_i,
  input  logic b_i,
  output logic hi_o,
  output logic lo_o
);
  cs_state_e st_q, st_eff, st_nxt;
  logic swap;

  always_comb begin
    // a start bit sees the cell as undecided
    st_eff = sow_i ? CS_EQ : st_q;
    st_nxt = st_eff;
    swap   = 1'b0;
    case (st_eff)
      CS_EQ: begin
        swap = b_i & ~a_i;
        if (a_i != b_i) st_nxt = a_i ? CS_PASS : CS_SWAP;
      end
      CS_SWAP: swap = 1'b1;
      default: swap = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= CS_EQ;
    else if (vld_i) st_q <= st_nxt;
  end

  assign hi_o = swap ? b_i : a_i;
  assign lo_o = swap ? a_i : b_i;
endmodule

// File: rtl/bsm_stage.sv
module bsm_stage #(
  parameter int NUM_LANES = 9,
  parameter bit TOP_RAIL  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 sow_i,
  input  logic [NUM_LANES-1:0] lane_i,
  input  logic                 rail_i,
  output logic [NUM_LANES-1:0] lane_o,
  output logic                 rail_o,
  output logic                 vld_o,
  output logic                 sow_o
);
  localparam int NPOS  = NUM_LANES + 1;
  localparam int NCELL = NPOS / 2;

  // position 0 is the top of the column
  logic [NPOS-1:0]      x, y;
  logic [NUM_LANES-1:0] lane_d;
  logic                 rail_d;

  if (TOP_RAIL) begin : g_rail_top
    assign x      = {lane_i, rail_i};
    assign rail_d = y[0];
    assign lane_d = y[NPOS-1:1];
  end else begin : g_rail_bot
    assign x      = {rail_i, lane_i};
    assign rail_d = y[NPOS-1];
    assign lane_d = y[NUM_LANES-1:0];
  end

  for (genvar j = 0; j < NCELL; j++) begin : g_cell
    bsm_cswap_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld_i),
      .sow_i (sow_i),
      .a_i   (x[2*j]),
      .b_i   (x[2*j+1]),
      .hi_o  (y[2*j]),
      .lo_o  (y[2*j+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_o <= '0;
      rail_o <= 1'b0;
      vld_o  <= 1'b0;
      sow_o  <= 1'b0;
    end else begin
      lane_o <= lane_d;
      rail_o <= rail_d;
      vld_o  <= vld_i;
      sow_o  <= sow_i & vld_i;
    end
  end
endmodule

// File: rtl/bit_serial_median.sv
module bit_serial_median #(
  parameter int NUM_LANES = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic                       sow_i,
  input  logic [NUM_LANES-1:0]       bits_i,
  input  logic [NUM_LANES/2-1:0]     ext_up_i,
  input  logic [(NUM_LANES+1)/2-1:0] ext_dn_i,
  output logic                       med_o,
  output logic [NUM_LANES-1:0]       sorted_o,
  output logic                       vld_o,
  output logic                       first_o,
  output logic                       last_o,
  output logic [NUM_LANES/2-1:0]     ext_up_o,
  output logic [(NUM_LANES+1)/2-1:0] ext_dn_o
);
  localparam int MID  = NUM_LANES / 2;
  localparam int LAST = NUM_LANES - 1;

  logic [NUM_LANES-1:0] lane_in [NUM_LANES];
  logic [NUM_LANES-1:0] lane_q  [NUM_LANES];
  logic [NUM_LANES-1:0] vld_in, sow_in, vld_q, sow_q;

  assign lane_in[0] = bits_i;
  assign vld_in[0]  = vld_i;
  assign sow_in[0]  = sow_i;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign lane_in[k] = lane_q[k-1];
      assign vld_in[k]  = vld_q[k-1];
      assign sow_in[k]  = sow_q[k-1];
    end
    if (k % 2 == 0) begin : g_even
      bsm_stage #(.NUM_LANES(NUM_LANES), .TOP_RAIL(1'b0)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (vld_in[k]),
        .sow_i (sow_in[k]),
        .lane_i(lane_in[k]),
        .rail_i(ext_dn_i[k/2]),
        .lane_o(lane_q[k]),
        .rail_o(ext_dn_o[k/2]),
        .vld_o (vld_q[k]),
        .sow_o (sow_q[k])
      );
    end else begin : g_odd
      bsm_stage #(.NUM_LANES(NUM_LANES), .TOP_RAIL(1'b1)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (vld_in[k]),
        .sow_i (sow_in[k]),
        .lane_i(lane_in[k]),
        .rail_i(ext_up_i[k/2]),
        .lane_o(lane_q[k]),
        .rail_o(ext_up_o[k/2]),
        .vld_o (vld_q[k]),
        .sow_o (sow_q[k])
      );
    end
  end

  // nearest valid bit behind the output decides the word end
  logic nxt_seen, nxt_sow;
  always_comb begin
    nxt_seen = 1'b0;
    nxt_sow  = 1'b0;
    for (int k = 0; k < LAST; k++) begin
      if (vld_q[k]) begin
        nxt_seen = 1'b1;
        nxt_sow  = sow_q[k];
      end
    end
  end

  assign sorted_o = lane_q[LAST];
  assign med_o    = lane_q[LAST][MID];
  assign vld_o    = vld_q[LAST];
  assign first_o  = sow_q[LAST];
  assign last_o   = vld_q[LAST] & (~nxt_seen | nxt_sow);
endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
  parameter int NUM_LANES = 9
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       vld_i,
  input logic                       sow_i,
  input logic [NUM_LANES/2-1:0]     ext_up_i,
  input logic [(NUM_LANES+1)/2-1:0] ext_dn_i,
  input logic                       vld_o,
  input logic                       last_o,
  input logic [NUM_LANES/2-1:0]     ext_up_o,
  input logic [(NUM_LANES+1)/2-1:0] ext_dn_o
);
  int inflight_q, words_q, lasts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q <= 0;
      words_q    <= 0;
      lasts_q    <= 0;
    end else begin
      inflight_q <= inflight_q + int'(vld_i) - int'(vld_o);
      words_q    <= words_q + int'(sow_i & vld_i);
      lasts_q    <= lasts_q + int'(last_o);
    end
  end

  // R5
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= NUM_LANES);

  // R6
  word_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lasts_q <= words_q) && (words_q - lasts_q <= NUM_LANES));

  // R4
  sow_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sow_i |-> vld_i);

  // R7
  rail_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ext_up_i) |=> (&ext_up_o));

  // R7
  rail_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~|ext_dn_i) |=> (~|ext_dn_o));
endmodule

bind bit_serial_median bsm_chk #(.NUM_LANES(NUM_LANES)) u_bsm_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vld_i   (vld_i),
  .sow_i   (sow_i),
  .ext_up_i(ext_up_i),
  .ext_dn_i(ext_dn_i),
  .vld_o   (vld_o),
  .last_o  (last_o),
  .ext_up_o(ext_up_o),
  .ext_dn_o(ext_dn_o)
);

// File: tb/bit_serial_median_bench.sv
module bit_serial_median_bench;
  localparam int N = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vld_i = 1'b0, sow_i = 1'b0;
  logic [8:0] bits_i = '0;
  logic [3:0] ext_up_i = '1;
  logic [4:0] ext_dn_i = '0;
  logic       med_o, vld_o, first_o, last_o;
  logic [8:0] sorted_o;
  logic [3:0] ext_up_o;
  logic [4:0] ext_dn_o;

  always #4 clk = ~clk;

  bit_serial_median #(.NUM_LANES(N)) u_bit_serial_median (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .sow_i(sow_i), .bits_i(bits_i),
    .ext_up_i(ext_up_i), .ext_dn_i(ext_dn_i), .med_o(med_o), .sorted_o(sorted_o),
    .vld_o(vld_o), .first_o(first_o), .last_o(last_o),
    .ext_up_o(ext_up_o), .ext_dn_o(ext_dn_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  int wr = 0, rd = 0;
  int exp_len [0:4095];
  int exp_t0  [0:4095];
  logic [8:0][7:0] exp_srt [0:4095];
  logic [31:0] lfsr = 32'h1ace5eed;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  function automatic logic [8:0][7:0] sort_desc(input logic [8:0][7:0] ws);
    logic [8:0][7:0] s = ws;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8 - i; j++)
        if (s[j] < s[j+1]) begin
          logic [7:0] t = s[j];
          s[j] = s[j+1];
          s[j+1] = t;
        end
    return s;
  endfunction

  // gap_every > 0 inserts one idle cycle before bit positions divisible by it
  task automatic send_word(input logic [8:0][7:0] ws, input int len, input int gap_every);
    int idx = wr;
    exp_srt[idx] = sort_desc(ws);
    exp_len[idx] = len;
    wr++;
    for (int b = len - 1; b >= 0; b--) begin
      if (gap_every > 0 && b != len - 1 && (b % gap_every) == 0) begin
        vld_i = 1'b0; sow_i = 1'b0; bits_i = ~bits_i;
        @(negedge clk);
      end
      vld_i = 1'b1;
      sow_i = (b == len - 1);
      for (int p = 0; p < 9; p++) bits_i[p] = ws[p][b];
      if (b == len - 1) exp_t0[idx] = cyc;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    vld_i = 1'b0; sow_i = 1'b0;
    step_rand();
    bits_i = lfsr[8:0];
    repeat (n) @(negedge clk);
  endtask

  // output monitor
  logic [8:0][7:0] acc;
  int nb = 0;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (vld_o) begin
        if (first_o) begin
          chk(rd < wr, "R6 output word without input word", rd, wr);
          chk(cyc - exp_t0[rd] == 9, "R3 first-bit latency", cyc - exp_t0[rd], 9);
          acc = '0;
          nb = 0;
        end
        for (int p = 0; p < 9; p++) acc[p] = {acc[p][6:0], sorted_o[p]};
        chk(med_o == sorted_o[4], "R1 median lane bit", int'(med_o), int'(sorted_o[4]));
        nb++;
        if (last_o) begin
          chk(acc[4] == exp_srt[rd][4], "R1 median word", int'(acc[4]), int'(exp_srt[rd][4]));
          for (int p = 0; p < 9; p++)
            chk(acc[p] == exp_srt[rd][p], "R2 sorted lane", int'(acc[p]), int'(exp_srt[rd][p]));
          chk(nb == exp_len[rd], "R6 word length between markers", nb, exp_len[rd]);
          chk(ext_up_o == 4'hf && ext_dn_o == 5'h0, "R7 tied rails",
              int'({ext_up_o, ext_dn_o}), 9'h1e0);
          rd++;
        end
      end else begin
        chk(!first_o && !last_o, "R5 markers on idle output", int'({first_o, last_o}), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired rd=%0d wr=%0d", rd, wr);
    summary();
    $finish;
  end

  initial begin
    logic [8:0][7:0] ws;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!med_o && !vld_o && !first_o && !last_o && sorted_o == '0, "R8 reset outputs",
        int'({med_o, vld_o, first_o, last_o, sorted_o}), 0);
    chk(ext_up_o == '0 && ext_dn_o == '0, "R8 reset rails", int'({ext_up_o, ext_dn_o}), 0);
    rst_ni = 1'b1;
    idle(2);

    // R1 all words equal
    for (int p = 0; p < 9; p++) ws[p] = 8'd5;
    send_word(ws, 4, 0);
    // R2 ascending by lane
    for (int p = 0; p < 9; p++) ws[p] = 8'(p);
    send_word(ws, 4, 0);
    // R4 duplicates, differences only in low bits, back to back
    for (int p = 0; p < 9; p++) ws[p] = (p % 3 == 0) ? 8'd12 : 8'(12 + (p % 2));
    send_word(ws, 4, 0);
    idle(12);

    // R1 exhaustive majority at word length 1, back to back
    for (int m = 0; m < 512; m++) begin
      for (int p = 0; p < 9; p++) ws[p] = {7'd0, m[p]};
      send_word(ws, 1, 0);
    end
    idle(3);

    // R4 R5 R6 random words at several lengths, with gaps and idle stretches
    for (int li = 0; li < 4; li++) begin
      int len = (li == 0) ? 2 : (li == 1) ? 3 : (li == 2) ? 5 : 8;
      for (int i = 0; i < 40; i++) begin
        for (int p = 0; p < 9; p++) begin
          step_rand();
          ws[p] = lfsr[7:0] & 8'((1 << len) - 1);
        end
        send_word(ws, len, (i % 3 == 0) ? 2 : 0);
        if (i % 7 == 6) idle(3);
      end
    end
    idle(20);
    chk(rd == wr, "R6 every word closed by last marker", rd, wr);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule